// File: doc/BRIEF.md
# Reset Cause Capture Controller

This block is the always-on reset manager of a chip. It watches brown-out detectors on three supply domains, a slow-clock loss detector, an external reset pin and two software requests: warm reset, and cold reset written through the register port. It turns every qualifying event into a chip-wide, active-high reset pulse of fixed minimum length. Each brown-out is qualified by the OR of an enable bit and an override bit, and each override bit can be frozen by a hardware lock input. Clock loss is qualified by its own enable bit.

The block keeps the root cause of the latest system reset as a 3-bit code. A request that arrives while a pulse is already running only lengthens that pulse and never replaces the cause. The cause becomes visible only once the pulse has ended. A new request that starts within a short guard window after that point is recorded as power-on, because the block cannot tell it apart from a consequence of the previous reset. Two sticky flags record a wakeup from shutdown and a wakeup caused by an IO event. Only the power-on reset input clears them.

All fields sit in one 32-bit word. A full-word write updates the control fields, and the word is read back combinationally.

Top module: `rstcause_ctrl`

## Requirements
- R1: After power-on reset (rst_ni low), the read word is 0x000000E0 and sys_rst_o is 0.
- R2: Brown-out index 0 (core), 1 (regulated) and 2 (IO supply) raise a reset only when its enable bit (word bits 5, 6, 7) or its override bit (word bits 9, 10, 11) is 1. When both are 0, the event has no effect.
- R3: Clock loss raises a reset only when the clock-loss enable (word bit 4, reset value 0) is 1.
- R4: The reset pin and the warm-reset request always raise a reset.
- R5: Writing a word with bit 31 set starts a reset with cause code 6, and bit 31 always reads 0.
- R6: sys_rst_o goes high at the first clock edge that samples a qualified request. It falls RST_CYCLES (default 4) edges after the last edge that samples one.
- R7: Cause codes are 0 power-on, 1 pin, 2 IO-supply brown-out, 3 core brown-out, 4 regulated brown-out, 5 clock loss, 6 cold reset, 7 warm reset. Among requests in the same cycle the lowest code wins. The code appears in word bits 3:1 at the edge where sys_rst_o falls.
- R8: Requests sampled while sys_rst_o is high lengthen the pulse and do not change the recorded cause.
- R9: A request first sampled within the GUARD_CYCLES (default 4) edges after the edge where sys_rst_o fell is recorded as code 0.
- R10: While ovr_lock_i[i] is 1, a write leaves override bit 9+i unchanged. Enable bits are still written.
- R11: Flags at word bit 15 (wakeup from shutdown) and bit 14 (IO-event wakeup) are set by wake_sd_i and wake_io_i. Writes and system resets cannot clear them; only power-on reset clears them, along with the cause.
- R12: Bits 31:16, 13:12, 8 and 0 read as 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on slow clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| brownout_i | input | 3 | Brown-out detect: 0 core, 1 regulated, 2 IO supply |
| clk_loss_i | input | 1 | Slow-clock loss detect |
| pin_rst_i | input | 1 | External reset pin request, active high |
| warm_req_i | input | 1 | Software warm-reset request |
| ovr_lock_i | input | 3 | Freezes the matching override bit against writes |
| wake_sd_i | input | 1 | Sets the wakeup-from-shutdown flag |
| wake_io_i | input | 1 | Sets the IO-event wakeup flag |
| reg_we_i | input | 1 | Full-word write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read word |
| sys_rst_o | output | 1 | Chip-wide reset pulse, active high |

## Verification
Two pairs of functions can land in the same cycle. The first is a cold-reset write together with a hardware source. The second is the end of one pulse together with the start of the next request. The bench provokes the first by writing bit 31 in the same cycle that random brown-out, pin, clock-loss and warm inputs are driven, and it checks that the lowest enabled code is recorded. It provokes the second by raising a request on the edge right after the fall of sys_rst_o and judges it by a recorded code of 0. It also checks that a request held a few edges later is recorded normally.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned NSUP       = 3;
  localparam int unsigned DW         = 32;
  localparam int unsigned CODE_W     = 3;
  localparam int unsigned BIT_COLD   = 31;
  localparam int unsigned BIT_WK_SD  = 15;
  localparam int unsigned BIT_WK_IO  = 14;
  localparam int unsigned OVR_LSB    = 9;
  localparam int unsigned EN_LSB     = 5;
  localparam int unsigned BIT_CLK_EN = 4;
  localparam int unsigned CAUSE_LSB  = 1;

  typedef enum logic [CODE_W-1:0] {
    CAUSE_POR  = 3'd0,
    CAUSE_PIN  = 3'd1,
    CAUSE_IOS  = 3'd2,
    CAUSE_CORE = 3'd3,
    CAUSE_REG  = 3'd4,
    CAUSE_CLK  = 3'd5,
    CAUSE_COLD = 3'd6,
    CAUSE_WARM = 3'd7
  } cause_e;

  // supply index to cause code: 0 core, 1 regulated, 2 IO supply
  function automatic cause_e sup_cause(input int unsigned idx);
    case (idx)
      0:       return CAUSE_CORE;
      1:       return CAUSE_REG;
      default: return CAUSE_IOS;
    endcase
  endfunction
endpackage

// File: rtl/rcc_rst_sync.sv
module rcc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rcc_regs.sv
module rcc_regs
  import rcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NSUP-1:0]   lock_i,
  input  logic              wake_sd_i,
  input  logic              wake_io_i,
  input  logic [CODE_W-1:0] cause_i,
  output logic [NSUP-1:0]   sup_en_o,
  output logic [NSUP-1:0]   sup_ovr_o,
  output logic              clk_en_o,
  output logic              cold_req_o,
  output logic [DW-1:0]     rdata_o
);
  logic [NSUP-1:0] en_q, en_d, ovr_q, ovr_d;
  logic clken_q, clken_d, sd_q, sd_d, io_q, io_d;
  logic unused_wbits;

  assign unused_wbits = ^{wdata_i[30:12], wdata_i[8], wdata_i[3:0]};

  always_comb begin
    en_d    = en_q;
    ovr_d   = ovr_q;
    clken_d = clken_q;
    if (we_i) begin
      clken_d = wdata_i[BIT_CLK_EN];
      for (int i = 0; i < NSUP; i++) begin
        en_d[i] = wdata_i[EN_LSB+i];
        if (!lock_i[i]) ovr_d[i] = wdata_i[OVR_LSB+i];
      end
    end
    sd_d = sd_q | wake_sd_i;
    io_d = io_q | wake_io_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '1;
      ovr_q   <= '0;
      clken_q <= 1'b0;
      sd_q    <= 1'b0;
      io_q    <= 1'b0;
    end else begin
      en_q    <= en_d;
      ovr_q   <= ovr_d;
      clken_q <= clken_d;
      sd_q    <= sd_d;
      io_q    <= io_d;
    end
  end

  always_comb begin
    rdata_o                        = '0;
    rdata_o[OVR_LSB +: NSUP]       = ovr_q;
    rdata_o[EN_LSB +: NSUP]        = en_q;
    rdata_o[BIT_CLK_EN]            = clken_q;
    rdata_o[CAUSE_LSB +: CODE_W]   = cause_i;
    rdata_o[BIT_WK_SD]             = sd_q;
    rdata_o[BIT_WK_IO]             = io_q;
  end

  assign sup_en_o   = en_q;
  assign sup_ovr_o  = ovr_q;
  assign clk_en_o   = clken_q;
  assign cold_req_o = we_i & wdata_i[BIT_COLD];

  for (genvar g = 0; g < NSUP; g++) begin : g_lock_chk
    assert_lock_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && lock_i[g]) |=> $stable(ovr_q[g]));
  end

  assert_sticky_sd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_q |=> sd_q);
  assert_sticky_io_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_q |=> io_q);
endmodule

// File: rtl/rcc_gate.sv
module rcc_gate
  import rcc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSUP-1:0] brownout_i,
  input  logic [NSUP-1:0] sup_en_i,
  input  logic [NSUP-1:0] sup_ovr_i,
  input  logic            clk_loss_i,
  input  logic            clk_en_i,
  input  logic            pin_i,
  input  logic            warm_i,
  input  logic            cold_i,
  output logic            req_o,
  output cause_e          code_o
);
  logic [NSUP-1:0] sup_hit;
  logic            clk_hit;

  always_comb begin
    for (int i = 0; i < NSUP; i++) begin
      sup_hit[i] = brownout_i[i] & (sup_en_i[i] | sup_ovr_i[i]);
    end
    clk_hit = clk_loss_i & clk_en_i;
    req_o   = pin_i | (|sup_hit) | clk_hit | cold_i | warm_i;
  end

  // lowest code wins: assign from weakest to strongest
  always_comb begin
    code_o = CAUSE_POR;
    if (warm_i)     code_o = CAUSE_WARM;
    if (cold_i)     code_o = CAUSE_COLD;
    if (clk_hit)    code_o = CAUSE_CLK;
    if (sup_hit[1]) code_o = CAUSE_REG;
    if (sup_hit[0]) code_o = CAUSE_CORE;
    if (sup_hit[2]) code_o = CAUSE_IOS;
    if (pin_i)      code_o = CAUSE_PIN;
  end

  assert_code_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (code_o != CAUSE_POR));
  assert_pin_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_i |-> (req_o && code_o == CAUSE_PIN));

  for (genvar g = 0; g < NSUP; g++) begin : g_sup_chk
    assert_gated_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (brownout_i[g] && !sup_en_i[g] && !sup_ovr_i[g]) |-> (code_o != sup_cause(g)));
  end
endmodule

// File: rtl/rcc_pulse.sv
module rcc_pulse
  import rcc_pkg::*;
#(
  parameter int unsigned RST_CYCLES   = 4,
  parameter int unsigned GUARD_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  cause_e            code_i,
  output logic              sys_rst_o,
  output logic [CODE_W-1:0] cause_o
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam int unsigned GW = $clog2(GUARD_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES);
  localparam logic [GW-1:0] GRD_LOAD = GW'(GUARD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [GW-1:0] grd_q, grd_d;
  cause_e        pend_q, pend_d, cause_q, cause_d;
  logic          starting, ending;

  always_comb begin
    starting = req_i && (cnt_q == '0);
    ending   = !req_i && (cnt_q == CW'(1));

    cnt_d = cnt_q;
    if (req_i)              cnt_d = CNT_LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);

    grd_d = grd_q;
    if (ending)             grd_d = GRD_LOAD;
    else if (grd_q != '0)   grd_d = grd_q - GW'(1);

    pend_d = pend_q;
    if (starting) pend_d = (grd_q != '0) ? CAUSE_POR : code_i;

    cause_d = ending ? pend_q : cause_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      grd_q   <= '0;
      pend_q  <= CAUSE_POR;
      cause_q <= CAUSE_POR;
    end else begin
      cnt_q   <= cnt_d;
      grd_q   <= grd_d;
      pend_q  <= pend_d;
      cause_q <= cause_d;
    end
  end

  assign sys_rst_o = (cnt_q != '0);
  assign cause_o   = cause_q;

  assert_req_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> sys_rst_o);
  assert_cause_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> $stable(cause_q));
  assert_commit_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cause_q) |-> $fell(sys_rst_o));
  assert_guard_por_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !sys_rst_o && grd_q != '0) |=> (pend_q == CAUSE_POR));
endmodule

// File: rtl/rstcause_ctrl.sv
module rstcause_ctrl
  import rcc_pkg::*;
#(
  parameter int unsigned RST_CYCLES   = 4,
  parameter int unsigned GUARD_CYCLES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      brownout_i,
  input  logic            clk_loss_i,
  input  logic            pin_rst_i,
  input  logic            warm_req_i,
  input  logic [2:0]      ovr_lock_i,
  input  logic            wake_sd_i,
  input  logic            wake_io_i,
  input  logic            reg_we_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  output logic            sys_rst_o
);
  logic              rst_sync_n;
  logic [NSUP-1:0]   sup_en, sup_ovr;
  logic              clk_en, cold_req, req;
  cause_e            code;
  logic [CODE_W-1:0] cause;

  rcc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  rcc_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .lock_i     (ovr_lock_i),
    .wake_sd_i  (wake_sd_i),
    .wake_io_i  (wake_io_i),
    .cause_i    (cause),
    .sup_en_o   (sup_en),
    .sup_ovr_o  (sup_ovr),
    .clk_en_o   (clk_en),
    .cold_req_o (cold_req),
    .rdata_o    (reg_rdata_o)
  );

  rcc_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .brownout_i (brownout_i),
    .sup_en_i   (sup_en),
    .sup_ovr_i  (sup_ovr),
    .clk_loss_i (clk_loss_i),
    .clk_en_i   (clk_en),
    .pin_i      (pin_rst_i),
    .warm_i     (warm_req_i),
    .cold_i     (cold_req),
    .req_o      (req),
    .code_o     (code)
  );

  rcc_pulse #(
    .RST_CYCLES   (RST_CYCLES),
    .GUARD_CYCLES (GUARD_CYCLES)
  ) u_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .req_i     (req),
    .code_i    (code),
    .sys_rst_o (sys_rst_o),
    .cause_o   (cause)
  );
endmodule

// File: tb/rstcause_ctrl_bench.sv
`timescale 1ns/1ps
module rstcause_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  brownout;
  logic        clk_loss, pin_rst, warm_req, wake_sd, wake_io, reg_we;
  logic [2:0]  ovr_lock;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sys_rst;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model of the register state
  logic [2:0] m_en, m_ovr;
  logic       m_clk, m_sd, m_io;
  logic [2:0] m_cause;

  always #2.5 clk = ~clk;

  rstcause_ctrl u_rstcause_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .brownout_i  (brownout),
    .clk_loss_i  (clk_loss),
    .pin_rst_i   (pin_rst),
    .warm_req_i  (warm_req),
    .ovr_lock_i  (ovr_lock),
    .wake_sd_i   (wake_sd),
    .wake_io_i   (wake_io),
    .reg_we_i    (reg_we),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .sys_rst_o   (sys_rst)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    logic [31:0] r = '0;
    r[15]   = m_sd;
    r[14]   = m_io;
    r[11:9] = m_ovr;
    r[7:5]  = m_en;
    r[4]    = m_clk;
    r[3:1]  = m_cause;
    return r;
  endfunction

  function automatic logic [31:0] ctrl_word(input logic [2:0] en, input logic [2:0] ov, input logic ck);
    logic [31:0] r = '0;
    r[11:9] = ov;
    r[7:5]  = en;
    r[4]    = ck;
    return r;
  endfunction

  // s: bit0 pin, bit1 IO supply, bit2 core, bit3 regulated, bit4 clock loss, bit5 warm
  function automatic logic [2:0] exp_code(input logic [5:0] s, input logic cold);
    if (s[0]) return 3'd1;
    if (s[1] && (m_en[2] || m_ovr[2])) return 3'd2;
    if (s[2] && (m_en[0] || m_ovr[0])) return 3'd3;
    if (s[3] && (m_en[1] || m_ovr[1])) return 3'd4;
    if (s[4] && m_clk) return 3'd5;
    if (cold) return 3'd6;
    if (s[5]) return 3'd7;
    return 3'd0;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    m_clk = d[4];
    m_en  = d[7:5];
    for (int i = 0; i < 3; i++) if (!ovr_lock[i]) m_ovr[i] = d[9+i];
  endtask

  task automatic drive_src(input logic [5:0] s);
    pin_rst     = s[0];
    brownout[2] = s[1];
    brownout[0] = s[2];
    brownout[1] = s[3];
    clk_loss    = s[4];
    warm_req    = s[5];
  endtask

  // one-cycle request, then measure pulse and recorded cause
  task automatic fire(input logic [5:0] s, input logic cold, input bit in_guard,
                      input int settle, input string req);
    logic [2:0] c;
    int n;
    c = exp_code(s, cold);
    drive_src(s);
    reg_we = cold;
    reg_wdata = ctrl_word(m_en, m_ovr, m_clk) | {cold, 31'd0};
    @(negedge clk);
    drive_src('0);
    reg_we = 1'b0; reg_wdata = '0;
    n = 0;
    while (sys_rst && n < 50) begin
      n++;
      @(negedge clk);
    end
    chk(n == ((c != 0) ? 4 : 0), {req, " R6 pulse length"}, n, (c != 0) ? 4 : 0);
    if (c != 0) m_cause = in_guard ? 3'd0 : c;
    chk(reg_rdata[3:1] == m_cause, {req, " R7 cause"}, reg_rdata[3:1], m_cause);
    idle(settle);
  endtask

  task automatic do_por();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    m_en = 3'b111; m_ovr = '0; m_clk = 1'b0; m_sd = 1'b0; m_io = 1'b0; m_cause = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R6 actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    brownout = '0; clk_loss = 0; pin_rst = 0; warm_req = 0; ovr_lock = '0;
    wake_sd = 0; wake_io = 0; reg_we = 0; reg_wdata = '0;
    do_por();

    // R1 reset state
    chk(reg_rdata == 32'h0000_00E0, "R1 read word", reg_rdata, 32'h0000_00E0);
    chk(sys_rst == 1'b0, "R1 sys_rst", sys_rst, 0);

    // R4 pin and warm
    fire(6'b000001, 0, 0, 5, "R4 pin");
    fire(6'b100000, 0, 0, 5, "R4 warm");

    // R2 supply gating, per supply
    wr(ctrl_word(3'b000, 3'b000, 0));
    fire(6'b000010, 0, 0, 5, "R2 IO gated off");
    fire(6'b000100, 0, 0, 5, "R2 core gated off");
    fire(6'b001000, 0, 0, 5, "R2 reg gated off");
    chk(reg_rdata == exp_word(), "R2 word after ignored events", reg_rdata, exp_word());
    wr(ctrl_word(3'b000, 3'b111, 0));
    fire(6'b000010, 0, 0, 5, "R2 IO override");
    fire(6'b001000, 0, 0, 5, "R2 reg override");
    wr(ctrl_word(3'b111, 3'b000, 0));
    fire(6'b000100, 0, 0, 5, "R2 core enable");

    // R3 clock loss
    fire(6'b010000, 0, 0, 5, "R3 clock loss disabled");
    wr(ctrl_word(3'b111, 3'b000, 1));
    fire(6'b010000, 0, 0, 5, "R3 clock loss enabled");

    // R5 cold reset write, bit 31 reads 0
    fire(6'b000000, 1, 0, 0, "R5 cold");
    chk(reg_rdata[31] == 1'b0, "R5 bit31 readback", reg_rdata, exp_word());
    idle(5);
    // R7 same-cycle: cold write with brown-out
    fire(6'b001000, 1, 0, 5, "R7 cold+reg brownout");
    fire(6'b100010, 1, 0, 5, "R7 warm+cold+IO");

    // R8 extension: warm, then pin during pulse
    warm_req = 1; n = 0;
    @(negedge clk); n += sys_rst; warm_req = 0;
    @(negedge clk); n += sys_rst; pin_rst = 1;
    @(negedge clk); n += sys_rst; pin_rst = 0;
    while (sys_rst && n < 50) begin
      @(negedge clk); n += sys_rst;
    end
    chk(n == 6, "R8 extended pulse length", n, 6);
    m_cause = 3'd7;
    chk(reg_rdata[3:1] == 3'd7, "R8 cause kept", reg_rdata[3:1], 3'd7);
    idle(5);

    // R9 guard window: back-to-back, then after the window
    fire(6'b000001, 0, 0, 0, "R9 first");
    fire(6'b000001, 0, 1, 0, "R9 inside guard");
    idle(5);
    fire(6'b100000, 0, 0, 5, "R9 after guard");

    // R10 override lock
    ovr_lock = 3'b100;
    wr(ctrl_word(3'b000, 3'b111, 0));
    chk(reg_rdata == exp_word(), "R10 locked override", reg_rdata, exp_word());
    chk(reg_rdata[11] == 1'b0, "R10 bit11 held", reg_rdata, exp_word());
    fire(6'b000010, 0, 0, 5, "R10 locked IO brownout ignored");
    ovr_lock = 3'b000;
    wr(ctrl_word(3'b000, 3'b111, 0));
    chk(reg_rdata[11:9] == 3'b111, "R10 unlocked write", reg_rdata, exp_word());

    // R12 reserved bits
    wr(32'h7FFF_FFFF & ~32'h0000_C000);
    chk((reg_rdata & 32'hFFFF_3101) == 0, "R12 reserved zero", reg_rdata, exp_word());
    chk(reg_rdata == exp_word(), "R12 full word", reg_rdata, exp_word());

    // R11 sticky flags
    wake_sd = 1; @(negedge clk); wake_sd = 0; m_sd = 1;
    wake_io = 1; @(negedge clk); wake_io = 0; m_io = 1;
    chk(reg_rdata == exp_word(), "R11 flags set", reg_rdata, exp_word());
    wr(32'h0);
    fire(6'b000001, 0, 0, 5, "R11 system reset");
    chk(reg_rdata[15:14] == 2'b11, "R11 flags survive", reg_rdata, exp_word());
    do_por();
    chk(reg_rdata == 32'h0000_00E0, "R11 power-on clears", reg_rdata, 32'h0000_00E0);

    // random stimulus
    for (int it = 0; it < 60; it++) begin
      logic [31:0] r;
      logic [5:0]  s;
      r = $urandom;
      wr(ctrl_word(r[2:0], r[5:3], r[6]));
      s = 6'($urandom) & 6'($urandom);
      fire(s, r[7] & r[8], 0, 5, "R7 random");
      chk(reg_rdata == exp_word(), "R2 random word", reg_rdata, exp_word());
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule